// File: doc/BRIEF.md
# Phase-Sequenced Grouped Serial Shift Register

A serial-in, parallel-out shift register whose data stages are split into small groups. No single clock event updates every group. A free-running phase counter feeds a one-hot decoder. The decoder raises exactly one group enable per clock, so a full shift of the register takes one clock per group. With the default sizes there are eight stages in four pairs, and a shift takes four clocks.

Every group has one extra holding stage. That stage captures the bit leaving the upstream group, and it does so in the clock where the upstream group fires, before that group is overwritten. The groups therefore fire in ascending order without the data racing through them. Group 0's holding stage captures the serial input in the clock where the last group fires. That clock is flagged on `shift_done`.

A user drives `din` and treats the bit present during a `shift_done` cycle as the next serial bit. The user reads `q` after the `shift_done` edge. Between those edges, `q` shows a partly shifted word.

Top module: `phased_pair_shifter`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `q` and all holding stages. After that edge, `phase_en` reads 4'b0001 and `shift_done` is low.
- R2: Exactly one bit of `phase_en` is high in every clock cycle.
- R3: Phase enables advance one position per clock in the order 0, 1, 2, 3, and phase 0 follows phase 3.
- R4: Phase g owns stages 2g and 2g+1, where `q[i]` is stage i. At a clock edge, only the stages of the group whose enable is high may change.
- R5: `shift_done` is high exactly in the cycle where the last phase enable (`phase_en[3]`) is high, so it pulses once every four clocks.
- R6: `din` is sampled only at the clock edge that ends a `shift_done` cycle. That bit appears at `q[0]` one edge later.
- R7: After the edge that ends a `shift_done` cycle, `q` equals the `q` from the previous such edge moved up by one stage. The sampled serial bit is in `q[0]`, and the old `q[7]` is dropped.
- R8: The first full shift after reset inserts a 0 at `q[0]`, whatever `din` holds.
- R9: A reset asserted in the middle of a shift restarts the sequence at phase 0 and discards the partial shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every stage updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data, sampled in `shift_done` cycles |
| q | output | 8 | Parallel view of all data stages, `q[i]` = stage i |
| phase_en | output | 4 | One-hot phase enables, bit g drives group g |
| shift_done | output | 1 | High in the last phase of every shift |

## Verification
The built-in assertions check, on every clock, that the phase enables are one-hot and advance in order, and that `shift_done` lines up with the last phase. They also check that groups not selected hold their stages, that a `shift_done` sample lands in stage 0 two edges later, and that reset lands in the documented state. Only the bench scenarios can show that whole words move by exactly one position over many shifts and that values cross the group boundaries intact. The same applies to the zero inserted on the first shift and to reset in mid-shift. The bench compares every cycle against a behavioural model of the partly shifted word.

// File: rtl/phased_pair_shifter.sv
module phased_pair_shifter #(
  parameter int STAGES    = 8,
  parameter int PER_GROUP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  output logic [STAGES-1:0] q,
  output logic [STAGES/PER_GROUP-1:0] phase_en,
  output logic              shift_done
);
  localparam int GROUPS = STAGES / PER_GROUP;
  localparam int CW     = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(GROUPS - 1);

  logic [CW-1:0]     cnt;
  logic [GROUPS-1:0] tail;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign phase_en   = GROUPS'(1) << cnt;
  assign shift_done = phase_en[GROUPS-1];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [PER_GROUP-1:0] st;
    logic                 hold;
    logic                 up_bit;
    logic                 up_fire;

    if (g == 0) begin : g_src
      assign up_bit  = din;
      assign up_fire = phase_en[GROUPS-1];
    end else begin : g_src
      assign up_bit  = tail[g-1];
      assign up_fire = phase_en[g-1];
    end

    always_ff @(posedge clk) begin
      if (rst)          hold <= 1'b0;
      else if (up_fire) hold <= up_bit;
    end

    always_ff @(posedge clk) begin
      if (rst) st <= '0;
      else if (phase_en[g]) begin
        if (PER_GROUP > 1) st <= {st[PER_GROUP-2:0], hold} ;
        else               st <= hold;
      end
    end

    assign tail[g] = st[PER_GROUP-1];
    assign q[g*PER_GROUP +: PER_GROUP] = st;

    assert_idle_group_holds_R4: assert property (@(posedge clk) disable iff (rst)
      !phase_en[g] |=> $stable(q[g*PER_GROUP +: PER_GROUP]));

    assert_phase_order_R3: assert property (@(posedge clk) disable iff (rst)
      phase_en[g] |=> phase_en[(g + 1) % GROUPS]);
  end

  assert_one_phase_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_en) == 1);

  assert_done_on_last_R5: assert property (@(posedge clk) disable iff (rst)
    shift_done |=> !shift_done && phase_en[0]);

  assert_serial_entry_R6: assert property (@(posedge clk) disable iff (rst)
    shift_done |-> ##2 (q[0] == $past(din, 2)));

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (q == '0 && phase_en == GROUPS'(1) && !shift_done));
endmodule

// File: tb/phased_pair_shifter_tb_top.sv
module phased_pair_shifter_tb_top;
  localparam int N = 8;
  localparam int G = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         din = 1'b1;
  logic [N-1:0] q;
  logic [G-1:0] phase_en;
  logic         shift_done;

  int checks = 0;
  int fails  = 0;

  int           m_cnt  = 0;
  logic [N-1:0] m_cur  = '0;
  logic [N-1:0] m_base = '0;
  logic         m_pend = 1'b0;
  bit           armed  = 1'b0;
  logic [15:0]  lfsr   = 16'hACE1;

  phased_pair_shifter #(.STAGES(N), .PER_GROUP(2)) dut_i (
    .clk(clk), .rst(rst), .din(din), .q(q),
    .phase_en(phase_en), .shift_done(shift_done)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // behavioural reference: groups reveal the shifted word one by one
  always @(posedge clk) begin
    logic [N-1:0] shifted;
    armed = 1'b1;
    if (rst) begin
      m_cnt = 0; m_cur = '0; m_base = '0; m_pend = 1'b0;
    end else begin
      shifted = {m_base[N-2:0], m_pend};
      for (int i = 2*m_cnt; i < 2*m_cnt + 2; i++) m_cur[i] = shifted[i];
      if (m_cnt == G-1) begin
        m_base = m_cur; m_pend = din; m_cnt = 0;
      end else m_cnt++;
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      chk(q == m_cur, "R4/R7 parallel word", 32'(q), 32'(m_cur));
      chk(phase_en == G'(1 << m_cnt), "R3 phase enable", 32'(phase_en), 32'(1 << m_cnt));
      chk($countones(phase_en) == 1, "R2 one-hot", 32'(phase_en), 32'd1);
      chk(shift_done == (m_cnt == G-1), "R5 done strobe", 32'(shift_done), 32'(m_cnt == G-1));
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(q == '0 && phase_en == 4'b0001 && !shift_done, "R1 reset state",
        {20'd0, 3'd0, shift_done, phase_en, q}, 32'h100);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(q == '0, "R8 first shift inserts zero", 32'(q), 32'd0);
    @(negedge clk);
    chk(q[0] == 1'b1, "R6 sampled bit in stage 0", 32'(q[0]), 32'd1);
    repeat (40) @(negedge clk);
    chk(q == 8'hFF, "R7 all ones after constant input", 32'(q), 32'hFF);
    din = 1'b0;
    repeat (40) @(negedge clk);
    chk(q == 8'h00, "R7 all zeros after constant input", 32'(q), 32'h00);
    for (int k = 0; k < 120; k++) begin
      din = (k % 8) < 4;
      @(negedge clk);
    end
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      din = lfsr[0];
      @(negedge clk);
    end
    while (phase_en != 4'b0100) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(phase_en == 4'b0001 && q == '0, "R9 mid-shift reset restart",
        {24'd0, phase_en, 4'd0} | 32'(q != 0), 32'h10);
    din = 1'b1;
    repeat (4) @(negedge clk);
    chk(q == '0, "R8 first shift after mid reset", 32'(q), 32'd0);
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      din = lfsr[3];
      @(negedge clk);
    end
    finish_run();
  end
endmodule